// File: doc/BRIEF.md
# Signed Compare and Skip Unit

This unit performs the algebraic (two's complement) comparison behind a compare-and-skip instruction. In single precision the 16-bit accumulator is compared with one memory word. In double precision a 32-bit value is compared with a 32-bit memory pair. The 32-bit value has the accumulator as its upper half and the accumulator extension as its lower half. The memory pair is the word at the effective address (upper half) and the word at the effective address plus one (lower half). The three-way outcome is turned into a skip distance that the sequencer adds to the instruction counter. Greater gives no skip, less skips one word, and equal skips two words.

The sequencer pulses `start` with the operands, the precision select and the low bit of the effective address all valid. One clock later the unit presents the skip count, raises `done` for one cycle and keeps the result until the next start. The double form needs an even effective address. An odd address in double precision raises `align_err` and forces the skip count to zero. The unit drives no arithmetic flags, so the overflow state kept elsewhere is never touched by a compare.

Top module: `cmp_skip_unit`

## Requirements
- R1: While reset is asserted and after it is released with no start, `skip` is 0, `align_err` is 0 and `done` is 0.
- R2: `done` is high in exactly the cycle after each cycle in which `start` was high, and at no other time.
- R3: In single precision (`dbl`=0), `skip` is 0 when signed `acc` > signed `mem_hi`, 1 when less, and 2 when equal.
- R4: In double precision (`dbl`=1, `ea_bit0`=0), the signed 32-bit value {`acc`,`ext`} is compared with {`mem_hi`,`mem_lo`}, giving `skip` 0 for greater, 1 for less and 2 for equal. The low words act as unsigned magnitude.
- R5: In double precision with `ea_bit0`=1, `align_err` is 1 and `skip` is 0, whatever the operands.
- R6: In single precision, `ea_bit0`, `ext` and `mem_lo` have no effect: `align_err` is 0 and `skip` depends only on `acc` and `mem_hi`.
- R7: `skip` and `align_err` change only in the cycle after a start and hold their values otherwise.
- R8: `skip` never takes the value 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Compare strobe; operands are sampled on this cycle |
| dbl | input | 1 | 1 selects double precision, 0 selects single precision |
| ea_bit0 | input | 1 | Low bit of the effective address |
| acc | input | 16 | Accumulator |
| ext | input | 16 | Accumulator extension (low half in double precision) |
| mem_hi | input | 16 | Word at the effective address |
| mem_lo | input | 16 | Word at the effective address plus one |
| skip | output | 2 | Skip distance in words: 0, 1 or 2 |
| align_err | output | 1 | Odd effective address on a double compare |
| done | output | 1 | One-cycle pulse in the cycle after start |

## Verification
The assertions check the timing contract on every cycle. They cover the done pulse following each start, the result holding between starts, the never-used skip code, the zero skip under an alignment error, and the single form never reporting misalignment. They also check that an equal verdict from the comparator becomes a two-word skip. Whether the signed ordering is right for each operand pattern can be shown only by the bench's scenarios. These cover sign boundaries, equal upper halves with differing lower halves in double precision, and the single form ignoring the extension words.

// File: rtl/cmp_skip_pkg.sv
package cmp_skip_pkg;
  typedef enum logic [1:0] {
    SKIP_NONE = 2'd0,
    SKIP_ONE  = 2'd1,
    SKIP_TWO  = 2'd2
  } skip_t;

  function automatic skip_t skip_of(input logic lt, input logic eq);
    if (eq)      return SKIP_TWO;
    else if (lt) return SKIP_ONE;
    else         return SKIP_NONE;
  endfunction
endpackage

// File: rtl/cmp_operand_mux.sv
module cmp_operand_mux #(
  parameter int W = 16,
  localparam int N = 2 * W
) (
  input  logic         dbl,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] ext,
  input  logic [W-1:0] mem_hi,
  input  logic [W-1:0] mem_lo,
  output logic [N-1:0] lhs,
  output logic [N-1:0] rhs
);
  // Single precision pads both low halves with zero, so the wide signed
  // ordering equals the ordering of the upper words alone.
  always_comb begin
    lhs = {acc, dbl ? ext : {W{1'b0}}};
    rhs = {mem_hi, dbl ? mem_lo : {W{1'b0}}};
  end
endmodule

// File: rtl/cmp_three_way.sv
module cmp_three_way #(
  parameter int N = 32
) (
  input  logic [N-1:0] lhs,
  input  logic [N-1:0] rhs,
  output logic         lt,
  output logic         eq
);
  function automatic logic signed_less(input logic [N-1:0] a, input logic [N-1:0] b);
    // Flip sign bits to turn signed order into unsigned order.
    logic [N-1:0] ab;
    logic [N-1:0] bb;
    ab = a ^ {1'b1, {(N-1){1'b0}}};
    bb = b ^ {1'b1, {(N-1){1'b0}}};
    return ab < bb;
  endfunction

  always_comb begin
    lt = signed_less(lhs, rhs);
    eq = (lhs == rhs);
  end
endmodule

// File: rtl/cmp_skip_reg.sv
module cmp_skip_reg
  import cmp_skip_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       misalign,
  input  logic       lt,
  input  logic       eq,
  output logic [1:0] skip,
  output logic       align_err,
  output logic       done
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      skip      <= SKIP_NONE;
      align_err <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        align_err <= misalign;
        skip      <= misalign ? SKIP_NONE : skip_of(lt, eq);
      end
    end
  end
endmodule

// File: rtl/cmp_skip_unit.sv
module cmp_skip_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         dbl,
  input  logic         ea_bit0,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] ext,
  input  logic [W-1:0] mem_hi,
  input  logic [W-1:0] mem_lo,
  output logic [1:0]   skip,
  output logic         align_err,
  output logic         done
);
  localparam int N = 2 * W;

  logic [N-1:0] lhs_w;
  logic [N-1:0] rhs_w;
  logic         cmp_lt;
  logic         cmp_eq;
  logic         misalign;

  assign misalign = dbl & ea_bit0;

  cmp_operand_mux #(.W(W)) u_mux (
    .dbl(dbl), .acc(acc), .ext(ext), .mem_hi(mem_hi), .mem_lo(mem_lo),
    .lhs(lhs_w), .rhs(rhs_w)
  );

  cmp_three_way #(.N(N)) u_cmp (
    .lhs(lhs_w), .rhs(rhs_w), .lt(cmp_lt), .eq(cmp_eq)
  );

  cmp_skip_reg u_reg (
    .clk(clk), .rst_n(rst_n), .start(start), .misalign(misalign),
    .lt(cmp_lt), .eq(cmp_eq),
    .skip(skip), .align_err(align_err), .done(done)
  );
endmodule

// File: rtl/cmp_skip_checker.sv
module cmp_skip_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       dbl,
  input logic       ea_bit0,
  input logic       cmp_eq,
  input logic [1:0] skip,
  input logic       align_err,
  input logic       done
);
  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);  // R2
  AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);  // R2
  AST_SKIP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    skip != 2'd3);  // R8
  AST_ALIGN_ZERO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> skip == 2'd0);  // R5
  AST_ODD_DOUBLE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && dbl && ea_bit0) |=> align_err);  // R5
  AST_SINGLE_NO_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !dbl) |=> !align_err);  // R6
  AST_EQUAL_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cmp_eq && !(dbl && ea_bit0)) |=> skip == 2'd2);  // R4
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(skip) && $stable(align_err)));  // R7
endmodule

bind cmp_skip_unit cmp_skip_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .dbl(dbl), .ea_bit0(ea_bit0),
  .cmp_eq(cmp_eq), .skip(skip), .align_err(align_err), .done(done)
);

// File: tb/cmp_skip_unit_test.sv
module cmp_skip_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        dbl = 1'b0;
  logic        ea_bit0 = 1'b0;
  logic [15:0] acc = '0, ext = '0, mem_hi = '0, mem_lo = '0;
  logic [1:0]  skip;
  logic        align_err, done;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cmp_skip_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .dbl(dbl), .ea_bit0(ea_bit0),
    .acc(acc), .ext(ext), .mem_hi(mem_hi), .mem_lo(mem_lo),
    .skip(skip), .align_err(align_err), .done(done)
  );

  function automatic logic [1:0] order_to_skip(input longint a, input longint b);
    if (a > b) return 2'd0;
    if (a < b) return 2'd1;
    return 2'd2;
  endfunction

  function automatic logic [1:0] model_skip(input logic d, input logic odd,
      input logic [15:0] a, input logic [15:0] x, input logic [15:0] h, input logic [15:0] l);
    longint la, lb;
    if (d && odd) return 2'd0;
    if (d) begin
      la = longint'($signed({a, x}));
      lb = longint'($signed({h, l}));
    end else begin
      la = longint'($signed(a));
      lb = longint'($signed(h));
    end
    return order_to_skip(la, lb);
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic run(input string req, input logic d, input logic odd,
      input logic [15:0] a, input logic [15:0] x, input logic [15:0] h, input logic [15:0] l);
    logic [1:0] es;
    logic       ea;
    es = model_skip(d, odd, a, x, h, l);
    ea = d & odd;
    @(negedge clk);
    start = 1'b1; dbl = d; ea_bit0 = odd; acc = a; ext = x; mem_hi = h; mem_lo = l;
    @(negedge clk);
    start = 1'b0;
    check({req, " skip"}, {30'b0, skip}, {30'b0, es});
    check("R5/R6 align_err", {31'b0, align_err}, {31'b0, ea});
    check("R2 done high", {31'b0, done}, 32'd1);
    // scramble inputs without a start: result must hold (R7)
    acc = ~a; mem_hi = h + 16'd1; dbl = ~d; ea_bit0 = ~odd;
    @(negedge clk);
    check("R2 done low", {31'b0, done}, 32'd0);
    check("R7 skip hold", {30'b0, skip}, {30'b0, es});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd12345;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check("R1 skip reset", {30'b0, skip}, 32'd0);
    check("R1 align reset", {31'b0, align_err}, 32'd0);
    check("R1 done reset", {31'b0, done}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 done idle", {31'b0, done}, 32'd0);
    check("R1 skip idle", {30'b0, skip}, 32'd0);

    run("R3 max>min", 0, 0, 16'h7FFF, 16'h0, 16'h8000, 16'h0);
    run("R3 min<max", 0, 0, 16'h8000, 16'h0, 16'h7FFF, 16'h0);
    run("R3 -1<0", 0, 0, 16'hFFFF, 16'h0, 16'h0000, 16'h0);
    run("R3 equal", 0, 0, 16'h1234, 16'h0, 16'h1234, 16'h0);
    run("R6 ext ignored", 0, 1, 16'h0005, 16'hFFFF, 16'h0005, 16'h0001);
    run("R4 low unsigned", 1, 0, 16'h0000, 16'h8000, 16'h0000, 16'h0001);
    run("R4 low less", 1, 0, 16'hFFFF, 16'h0001, 16'hFFFF, 16'hFFFE + 16'd1);
    run("R4 equal", 1, 0, 16'h8000, 16'h0000, 16'h8000, 16'h0000);
    run("R4 sign", 1, 0, 16'h8000, 16'hFFFF, 16'h7FFF, 16'h0000);
    run("R5 odd equal", 1, 1, 16'h4444, 16'h1, 16'h4444, 16'h1);
    run("R5 odd less", 1, 1, 16'h8000, 16'h0, 16'h7FFF, 16'h0);

    for (int i = 0; i < 400; i++) begin
      logic d, o;
      logic [15:0] a, x, h, l;
      d = 1'($urandom); o = ($urandom % 5) == 0;
      a = 16'($urandom); x = 16'($urandom);
      h = (($urandom % 4) == 0) ? a : 16'($urandom);
      l = (($urandom % 3) == 0) ? x : 16'($urandom);
      run(d ? "R4 random" : "R3 random", d, o, a, x, h, l);
    end

    check("R8 skip legal", {31'b0, skip == 2'd3}, 32'd0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule